// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

This block produces up to six servo-style pulse trains that all share one repetition period. A prescaler turns the system clock into a count tick. A period counter steps on that tick and returns to zero after reaching the active period value. Each channel drives its output high from the start of a period until the counter reaches that channel's compare value. The result is a single-edge pulse whose width is set in ticks.

Software writes the period, the compare values and the per-channel lower and upper limits into a small register file. Written values stay in shadow storage until a commit request is issued. The request carries a latch mask, which selects the period and/or the channels to update, and a channel enable vector. The block holds the request as pending and applies it at the next period wrap, so no pulse is ever cut short or stretched. When a compare value is applied it is clamped to its channel limits and to a guard margin below the incoming period. Wrap and compare-match events set sticky flags, which are cleared by writing ones.

Top module: `servo_pwm_gen`

## Requirements
- R1: A count tick occurs once every `prescale_i + 1` clock cycles, so a full period lasts `(period + 1) * (prescale_i + 1)` clock cycles.
- R2: The period counter counts ticks from 0 up to the active period value and then returns to 0; that return is the wrap event. After reset the period value is `PERIOD_RST`.
- R3: An enabled channel with active compare value C drives its output high during counter values 0 to C-1 and low for the rest of the period, so it is high for C ticks.
- R4: Register writes change only shadow storage. Outputs are unaffected until a commit is applied at a wrap. The applied latch mask selects what is copied: bit 0 selects the period, and bit k (1 to 6) selects channel k-1. Unselected registers keep their active values.
- R5: A committed nonzero compare value v becomes max(min(v, min(upper, P - 200)), lower). Here P is the period in force after the same commit, and lower and upper are that channel's limit registers (reset values 0 and all ones).
- R6: A compare value of zero bypasses the clamp and keeps the output low for the whole period.
- R7: An accepted commit raises `commit_pending_o` from the next cycle until the wrap that applies it. `commit_done_o` is then high for exactly one cycle, and `commit_pending_o` is low in that same cycle. A commit request made while one is pending, including in the applying cycle itself, is ignored.
- R8: Each commit also carries an enable vector that replaces all channel enables at the same wrap. A disabled channel's output stays low.
- R9: `flag_o` bit 0 sets on each wrap, and bit k sets when enabled channel k-1 with a nonzero compare value C sees a tick at counter value C. Flags stay set until a 1 is written to the same bit of `flag_clr_i`. A set in the same cycle as a clear wins.
- R10: While `rst_ni` is low, all outputs and flags are low, nothing is pending, all shadow and active compare values are 0, and all channels are disabled.
- R11: Register addresses are: 0 for the period; 1 to 6 for the channel compare values; 7 to 12 for the lower limits; 13 to 18 for the upper limits. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | PRE_W | Tick divider value; a tick occurs every value+1 clocks |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address (see R11) |
| wr_data_i | input | CNT_W | Register write data |
| commit_i | input | 1 | Commit request |
| commit_mask_i | input | N_CH+1 | Latch mask: bit 0 selects the period, bits 1..N_CH select the channels |
| commit_en_i | input | N_CH | Channel enables applied with the commit |
| flag_clr_i | input | N_CH+1 | Write-one-to-clear for the flags |
| commit_pending_o | output | 1 | A commit is waiting for the next wrap |
| commit_done_o | output | 1 | One-cycle pulse when a commit has been applied |
| flag_o | output | N_CH+1 | Sticky flags: bit 0 for wrap, bits 1..N_CH for channel matches |
| pwm_o | output | N_CH | Channel pulse outputs |

## Verification
Two functions can fall in the same cycle: a flag being set by a wrap, and that same flag being cleared. The bench holds the clear mask at all ones across a wrap. It then expects the wrap flag to read high in the cycle after the wrap and low one cycle later. It also issues a second commit while the first is still pending and confirms that the applied values come from the first commit. A behavioural reference model, updated every cycle, compares the outputs, flags, pending and done signals on every clock. This catches any cycle where a wrap, a commit and a compare match coincide.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

  typedef enum logic [1:0] {
    K_PERIOD,
    K_CMP,
    K_LOWER,
    K_UPPER
  } reg_kind_e;

  // register address of a given kind for channel ch, n channels in total
  function automatic int unsigned reg_addr(reg_kind_e k, int unsigned ch, int unsigned n);
    case (k)
      K_PERIOD: return 0;
      K_CMP:    return 1 + ch;
      K_LOWER:  return 1 + n + ch;
      default:  return 1 + 2 * n + ch;
    endcase
  endfunction

endpackage

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q;

  // >= keeps the divider sane if the prescale value drops mid-count
  assign tick_o = (pre_q >= prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/servo_period_ctr.sv
module servo_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/servo_regfile.sv
module servo_regfile
  import servo_pwm_pkg::*;
#(
  parameter int N_CH       = 6,
  parameter int CNT_W      = 16,
  parameter int AW         = 5,
  parameter int PERIOD_RST = 19999
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [AW-1:0]               wr_addr_i,
  input  logic [CNT_W-1:0]            wr_data_i,
  output logic [CNT_W-1:0]            sh_period_o,
  output logic [N_CH-1:0][CNT_W-1:0]  sh_cmp_o,
  output logic [N_CH-1:0][CNT_W-1:0]  lower_o,
  output logic [N_CH-1:0][CNT_W-1:0]  upper_o
);

  localparam logic [AW-1:0] A_PER = AW'(reg_addr(K_PERIOD, 0, N_CH));

  logic [CNT_W-1:0] per_q;
  assign sh_period_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            per_q <= CNT_W'(PERIOD_RST);
    else if (wr_en_i && wr_addr_i == A_PER) per_q <= wr_data_i;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CMP = AW'(reg_addr(K_CMP,   i, N_CH));
    localparam logic [AW-1:0] A_LO  = AW'(reg_addr(K_LOWER, i, N_CH));
    localparam logic [AW-1:0] A_HI  = AW'(reg_addr(K_UPPER, i, N_CH));

    logic [CNT_W-1:0] cmp_q, lo_q, hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q <= '0;
        lo_q  <= '0;
        hi_q  <= '1;
      end else if (wr_en_i) begin
        if (wr_addr_i == A_CMP) cmp_q <= wr_data_i;
        if (wr_addr_i == A_LO)  lo_q  <= wr_data_i;
        if (wr_addr_i == A_HI)  hi_q  <= wr_data_i;
      end
    end

    assign sh_cmp_o[i] = cmp_q;
    assign lower_o[i]  = lo_q;
    assign upper_o[i]  = hi_q;
  end

endmodule

// File: rtl/servo_commit_ctl.sv
module servo_commit_ctl #(
  parameter int N_CH       = 6,
  parameter int CNT_W      = 16,
  parameter int PERIOD_RST = 19999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             commit_i,
  input  logic [N_CH:0]    commit_mask_i,
  input  logic [N_CH-1:0]  commit_en_i,
  input  logic [CNT_W-1:0] sh_period_i,
  output logic             pending_o,
  output logic             done_o,
  output logic             apply_o,
  output logic [N_CH:0]    lmask_o,
  output logic [N_CH-1:0]  en_new_o,
  output logic [CNT_W-1:0] period_act_o
);

  logic             pend_q, done_q;
  logic [N_CH:0]    lmask_q;
  logic [N_CH-1:0]  en_q;
  logic [CNT_W-1:0] per_q;

  assign apply_o      = wrap_i && pend_q;
  assign pending_o    = pend_q;
  assign done_o       = done_q;
  assign lmask_o      = lmask_q;
  assign en_new_o     = en_q;
  assign period_act_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      lmask_q <= '0;
      en_q    <= '0;
      per_q   <= CNT_W'(PERIOD_RST);
    end else begin
      done_q <= apply_o;
      if (apply_o) begin
        pend_q  <= 1'b0;
        lmask_q <= '0;  // latch bits self-clear
        if (lmask_q[0]) per_q <= sh_period_i;
      end else if (commit_i && !pend_q) begin
        pend_q  <= 1'b1;
        lmask_q <= commit_mask_i;
        en_q    <= commit_en_i;
      end
    end
  end

endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             apply_i,
  input  logic             latch_i,
  input  logic             en_new_i,
  input  logic [CNT_W-1:0] sh_cmp_i,
  input  logic [CNT_W-1:0] lower_i,
  input  logic [CNT_W-1:0] upper_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o,
  output logic             match_o
);

  logic             en_q;
  logic [CNT_W-1:0] cmp_q, hi, clamped;

  always_comb begin
    hi      = (upper_i < lim_i) ? upper_i : lim_i;
    clamped = sh_cmp_i;
    if (sh_cmp_i != '0) begin  // zero means off, exempt from clamp
      if (clamped > hi)      clamped = hi;
      if (clamped < lower_i) clamped = lower_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cmp_q <= '0;
    end else if (apply_i) begin
      en_q <= en_new_i;
      if (latch_i) cmp_q <= clamped;
    end
  end

  assign pwm_o   = en_q && (cnt_i < cmp_q);
  assign match_o = tick_i && en_q && (cmp_q != '0) && (cnt_i == cmp_q);

endmodule

// File: rtl/servo_pwm_gen.sv
module servo_pwm_gen #(
  parameter int  N_CH       = 6,
  parameter int  CNT_W      = 16,
  parameter int  PRE_W      = 8,
  parameter int  GUARD      = 200,
  parameter int  PERIOD_RST = 19999,
  localparam int AW         = $clog2(3 * N_CH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             commit_i,
  input  logic [N_CH:0]    commit_mask_i,
  input  logic [N_CH-1:0]  commit_en_i,
  input  logic [N_CH:0]    flag_clr_i,
  output logic             commit_pending_o,
  output logic             commit_done_o,
  output logic [N_CH:0]    flag_o,
  output logic [N_CH-1:0]  pwm_o
);

  logic                       tick, wrap, apply;
  logic [CNT_W-1:0]           cnt, period_act, sh_period, new_period, lim;
  logic [N_CH-1:0][CNT_W-1:0] sh_cmp, lower, upper;
  logic [N_CH:0]              lmask, flag_q;
  logic [N_CH-1:0]            en_new, match;

  servo_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk_i, .rst_ni, .prescale_i, .tick_o(tick)
  );

  servo_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .tick_i(tick), .period_i(period_act), .cnt_o(cnt), .wrap_o(wrap)
  );

  servo_regfile #(.N_CH(N_CH), .CNT_W(CNT_W), .AW(AW), .PERIOD_RST(PERIOD_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sh_period_o(sh_period), .sh_cmp_o(sh_cmp), .lower_o(lower), .upper_o(upper)
  );

  servo_commit_ctl #(.N_CH(N_CH), .CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_commit (
    .clk_i, .rst_ni, .wrap_i(wrap), .commit_i, .commit_mask_i, .commit_en_i,
    .sh_period_i(sh_period), .pending_o(commit_pending_o), .done_o(commit_done_o),
    .apply_o(apply), .lmask_o(lmask), .en_new_o(en_new), .period_act_o(period_act)
  );

  // clamp ceiling follows the period that takes effect with this commit
  assign new_period = lmask[0] ? sh_period : period_act;
  assign lim = (new_period > CNT_W'(GUARD)) ? new_period - CNT_W'(GUARD) : '0;

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    servo_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni, .tick_i(tick), .apply_i(apply), .latch_i(lmask[i+1]),
      .en_new_i(en_new[i]), .sh_cmp_i(sh_cmp[i]), .lower_i(lower[i]), .upper_i(upper[i]),
      .lim_i(lim), .cnt_i(cnt), .pwm_o(pwm_o[i]), .match_o(match[i])
    );
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr_i) | {match, wrap};
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/servo_pwm_gen_chk.sv
module servo_pwm_gen_chk #(
  parameter int N_CH  = 6,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wrap_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] period_i,
  input logic [N_CH:0]    lmask_i,
  input logic             pending_i,
  input logic             done_i,
  input logic [N_CH:0]    flag_i,
  input logic [N_CH:0]    flag_clr_i,
  input logic [N_CH-1:0]  pwm_i
);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= period_i);

  assert_done_after_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(pending_i) && !pending_i));

  assert_pending_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i && !wrap_i) |=> (pending_i && $stable(lmask_i)));

  assert_wrap_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_i[0]);

  for (genvar i = 0; i <= N_CH; i++) begin : g_flag
    assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && !flag_clr_i[i]) |=> flag_i[i]);
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_pwm
    assert_rise_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_i[i]) |-> $past(wrap_i));
  end

endmodule

bind servo_pwm_gen servo_pwm_gen_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .cnt_i(cnt), .period_i(period_act),
  .lmask_i(lmask), .pending_i(commit_pending_o), .done_i(commit_done_o),
  .flag_i(flag_o), .flag_clr_i(flag_clr_i), .pwm_i(pwm_o)
);

// File: tb/servo_pwm_gen_bench.sv
module servo_pwm_gen_bench;

  localparam int P = 299;
  localparam int G = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] prescale = '0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic       commit = 1'b0;
  logic [6:0] commit_mask = '0;
  logic [5:0] commit_en = '0;
  logic [6:0] flag_clr = '0;
  logic       pending, done;
  logic [6:0] flag;
  logic [5:0] pwm;

  always #2.5 clk = ~clk;

  servo_pwm_gen #(.PERIOD_RST(P), .GUARD(G)) u_servo_pwm_gen (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(prescale), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .commit_i(commit),
    .commit_mask_i(commit_mask), .commit_en_i(commit_en), .flag_clr_i(flag_clr),
    .commit_pending_o(pending), .commit_done_o(done), .flag_o(flag), .pwm_o(pwm)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_pre, m_cnt, m_per, m_shper;
  int m_sh[6], m_lo[6], m_hi[6], m_cmp[6];
  bit m_en[6];
  bit m_pend, m_done;
  bit [6:0] m_lm, m_flag, m_set;
  bit [5:0] m_enp;
  bit m_tick, m_wrap, m_apply;
  int m_np, m_lim, m_top, m_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_per = P; m_shper = P;
      for (int i = 0; i < 6; i++) begin
        m_sh[i] = 0; m_lo[i] = 0; m_hi[i] = 65535; m_cmp[i] = 0; m_en[i] = 0;
      end
      m_pend = 0; m_done = 0; m_lm = '0; m_enp = '0; m_flag = '0;
    end else begin
      m_tick  = (m_pre >= int'(prescale));
      m_wrap  = m_tick && (m_cnt == m_per);
      m_apply = m_wrap && m_pend;
      m_set = '0;
      m_set[0] = m_wrap;
      for (int i = 0; i < 6; i++)
        m_set[i+1] = m_tick && m_en[i] && (m_cmp[i] != 0) && (m_cnt == m_cmp[i]);
      m_flag = (m_flag & ~flag_clr) | m_set;
      m_done = m_apply;
      if (m_apply) begin
        m_np  = m_lm[0] ? m_shper : m_per;
        m_lim = (m_np > G) ? m_np - G : 0;
        for (int i = 0; i < 6; i++) begin
          if (m_lm[i+1]) begin
            m_top = (m_hi[i] < m_lim) ? m_hi[i] : m_lim;
            m_v = m_sh[i];
            if (m_v != 0) begin
              if (m_v > m_top) m_v = m_top;
              if (m_v < m_lo[i]) m_v = m_lo[i];
            end
            m_cmp[i] = m_v;
          end
          m_en[i] = m_enp[i];
        end
        m_per = m_np; m_pend = 0; m_lm = '0;
      end else if (commit && !m_pend) begin
        m_pend = 1; m_lm = commit_mask; m_enp = commit_en;
      end
      if (wr_en) begin
        if (wr_addr == 0) m_shper = wr_data;
        else if (wr_addr <= 6)  m_sh[wr_addr-1]  = wr_data;
        else if (wr_addr <= 12) m_lo[wr_addr-7]  = wr_data;
        else if (wr_addr <= 18) m_hi[wr_addr-13] = wr_data;
      end
      if (m_wrap) m_cnt = 0;
      else if (m_tick) m_cnt++;
      m_pre = m_tick ? 0 : m_pre + 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic bit [5:0] exp_pwm;
      for (int i = 0; i < 6; i++) exp_pwm[i] = m_en[i] && (m_cnt < m_cmp[i]);
      chk("R3 model pwm", int'(pwm), int'(exp_pwm));
      chk("R9 model flags", int'(flag), int'(m_flag));
      chk("R7 model pending", int'(pending), int'(m_pend));
      chk("R7 model done", int'(done), int'(m_done));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_commit(bit [6:0] mask, bit [5:0] en);
    @(posedge clk); #1;
    commit = 1'b1; commit_mask = mask; commit_en = en;
    @(posedge clk); #1;
    commit = 1'b0;
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk("R7 done pulse seen", int'(seen), 1);
  endtask

  int hi_cnt[6];

  // called at the negedge where done is high (counter at 0)
  task automatic measure(int n);
    for (int i = 0; i < 6; i++) hi_cnt[i] = 0;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 6; i++) if (pwm[i]) hi_cnt[i]++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog R7: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 pwm after reset", int'(pwm), 0);
    chk("R10 flags after reset", int'(flag), 0);
    chk("R10 pending after reset", int'(pending), 0);

    // scenario A: basic widths, clamp, zero, ignored second commit
    wr(1, 40); wr(2, 250); wr(3, 0);
    wr(10, 10); wr(4, 5);
    wr(17, 30); wr(5, 60);
    wr(6, 70);
    do_commit(7'b1111110, 6'h3f);
    @(negedge clk);
    chk("R7 pending after commit", int'(pending), 1);
    chk("R4 outputs before wrap", int'(pwm), 0);
    do_commit(7'h7f, 6'h00);
    wait_done();
    chk("R7 pending cleared on done", int'(pending), 0);
    measure(P + 1);
    chk("R3 ch0 width", hi_cnt[0], 40);
    chk("R5 ch1 clamp to guard", hi_cnt[1], 99);
    chk("R6 ch2 zero", hi_cnt[2], 0);
    chk("R5 ch3 lower limit", hi_cnt[3], 10);
    chk("R5 ch4 upper limit", hi_cnt[4], 30);
    chk("R3 ch5 width", hi_cnt[5], 70);

    // scenario B: masked commit touches only ch0
    wr(1, 20); wr(2, 30);
    do_commit(7'b0000010, 6'h3f);
    wait_done();
    measure(P + 1);
    chk("R4 ch0 latched", hi_cnt[0], 20);
    chk("R4 ch1 not latched", hi_cnt[1], 99);

    // scenario C: new period, clamp follows new period
    wr(2, 250); wr(0, 399);
    do_commit(7'b0000101, 6'h3f);
    wait_done();
    measure(400);
    chk("R5 ch1 clamp new period", hi_cnt[1], 199);
    chk("R2 ch0 width new period", hi_cnt[0], 20);
    chk("R2 next period starts", int'(pwm[0]), 1);

    // scenario D: enables only
    do_commit(7'b0000000, 6'b000001);
    wait_done();
    measure(400);
    chk("R8 ch0 enabled", hi_cnt[0], 20);
    chk("R8 ch1 disabled", hi_cnt[1], 0);
    chk("R8 ch5 disabled", hi_cnt[5], 0);

    // scenario E: prescaler
    @(posedge clk); #1 prescale = 8'd2;
    do_commit(7'b0000000, 6'b000011);
    wait_done();
    measure(1200);
    chk("R1 ch0 scaled width", hi_cnt[0], 60);
    chk("R1 ch1 scaled width", hi_cnt[1], 597);

    // scenario G: unmapped address ignored, full re-latch
    wr(20, 5); wr(31, 1);
    do_commit(7'h7f, 6'h3f);
    wait_done();
    measure(1200);
    chk("R11 ch0", hi_cnt[0], 60);
    chk("R11 ch1", hi_cnt[1], 597);
    chk("R11 ch2", hi_cnt[2], 0);
    chk("R11 ch3", hi_cnt[3], 30);
    chk("R11 ch4", hi_cnt[4], 90);
    chk("R11 ch5", hi_cnt[5], 210);

    // scenario F: set and clear of the wrap flag in the same cycle
    @(posedge clk); #1 flag_clr = 7'h7f;
    begin
      bit seen = 0;
      for (int k = 0; k < 3000 && !seen; k++) begin
        @(negedge clk);
        if (flag[0]) seen = 1;
      end
      chk("R9 set wins over clear", int'(seen), 1);
      @(negedge clk);
      chk("R9 cleared next cycle", int'(flag[0]), 0);
    end
    @(posedge clk); #1 flag_clr = '0;
    repeat (20) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule